// File: doc/BRIEF.md
# Serial Avionics Word Transmitter

This block turns one 32-bit avionics data word into a serial bit stream. The host presents the word together with a label-order select and pulses a load input. The block assembles a transmit frame: an 8-bit label, optionally bit-reversed; a 23-bit data field; and an odd parity bit that the block generates itself. It then sends the frame one bit per bit-time strobe.

The label goes first and the parity bit goes last. The label is sent most significant bit first, while the data field is sent least significant bit first, so the two fields have opposite significance on the wire. Each new bit is marked by a one-clock valid pulse. A done pulse closes the word on the strobe that ends bit 32.

The line driver, inter-word gap timing and any queuing sit outside this block. The host paces words by watching the busy flag or the done pulse.

Top module: `a429_word_tx`

## Requirements
- R1: While reset is asserted, and after it is released with no load, the block is idle: `ser_o`, `bit_vld_o`, `done_o` and `busy_o` are all 0.
- R2: With `flip_i` = 0 at load, transmitted bits 1 to 8 are `word_i[7]`, `word_i[6]`, ..., `word_i[0]`, in that order.
- R3: With `flip_i` = 1 at load, transmitted bits 1 to 8 are `word_i[0]`, `word_i[1]`, ..., `word_i[7]`, in that order.
- R4: Transmitted bits 9 to 31 are `word_i[8]` up to `word_i[30]`, in ascending index order.
- R5: Transmitted bit 32 is chosen so that bits 1 to 32 together hold an odd number of ones. `word_i[31]` has no effect on any transmitted bit.
- R6: Each `bit_tick_i` pulse while busy presents the next bit on `ser_o` in the clock after the strobe. `bit_vld_o` pulses for exactly that clock. `ser_o` holds between strobes. A strobe while idle changes nothing.
- R7: The 33rd strobe after a load ends the word. In the clock after that strobe, `done_o` is 1 for one clock, `busy_o` is 0 and `ser_o` is 0.
- R8: A load is accepted only while `busy_o` is 0, and `busy_o` rises in the clock after an accepted load. A load while busy is ignored: the word in flight continues unchanged and no second word follows.
- R9: `word_i` and `flip_i` are captured at the accepted load. Changing them during transmission has no effect on the word in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load request for `word_i` |
| word_i | input | 32 | Word: [7:0] label, [30:8] data (bit 8 = data LSB), [31] ignored |
| flip_i | input | 1 | 1 = send label in reversed bit order |
| bit_tick_i | input | 1 | One-clock bit-time strobe |
| ser_o | output | 1 | Serial data, held for one bit time |
| bit_vld_o | output | 1 | One-clock pulse when a new bit appears on `ser_o` |
| done_o | output | 1 | One-clock pulse when the word is complete |
| busy_o | output | 1 | A word is in flight |

## Verification
The bench sends words in both label orders, with asymmetric labels and with data patterns of both parities. A design that mixed up the label significance, or applied the flip the wrong way round, would put the wrong bits in positions 1 to 8. Parity is checked on words whose top bit is set against the computed parity; a design that forwarded that bit, or generated even parity, would fail the bit-32 check. The bench also issues a load in the middle of a word and changes `flip_i` during a word; a design without load gating or input capture would corrupt the remaining bits or start a second word. Reset in the middle of a word, and strobes while idle, must leave the line low and the block idle.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;
  localparam int unsigned WORD_BITS  = 32;
  localparam int unsigned LABEL_BITS = 8;

  typedef enum logic [0:0] {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;
endpackage

// File: rtl/a429_rst_sync.sv
module a429_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_core_n = sync_q[STAGES-1];
endmodule

// File: rtl/a429_label_order.sv
module a429_label_order #(
  parameter int unsigned LABEL_W = 8
) (
  input  logic [LABEL_W-1:0] label_i,
  input  logic               flip_i,
  output logic [LABEL_W-1:0] tx_label_o   // [0] is sent first
);
  logic [LABEL_W-1:0] msb_first;

  // Default order: the label MSB is the first bit on the wire.
  for (genvar gi = 0; gi < LABEL_W; gi++) begin : g_rev
    assign msb_first[gi] = label_i[LABEL_W-1-gi];
  end

  assign tx_label_o = flip_i ? label_i : msb_first;
endmodule

// File: rtl/a429_parity_gen.sv
module a429_parity_gen #(
  parameter int unsigned BODY_W = 31
) (
  input  logic [BODY_W-1:0] body_i,
  output logic              par_o
);
  // Odd parity: body plus parity bit holds an odd count of ones.
  assign par_o = ~(^body_i);
endmodule

// File: rtl/a429_bit_shifter.sv
module a429_bit_shifter
  import a429_tx_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] frame_i,   // [0] is sent first
  input  logic              tick_i,
  output logic              ser_o,
  output logic              bit_vld_o,
  output logic              done_o,
  output logic              busy_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORD_W);

  tx_state_e         state_q, state_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              ser_q, ser_d;
  logic              vld_q, vld_d;
  logic              done_q, done_d;

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    ser_d   = ser_q;
    vld_d   = 1'b0;
    done_d  = 1'b0;
    unique case (state_q)
      TX_IDLE: begin
        ser_d = 1'b0;
        if (load_i) begin
          state_d = TX_SEND;
          sh_d    = frame_i;
          cnt_d   = '0;
        end
      end
      TX_SEND: begin
        if (tick_i) begin
          if (cnt_q == LAST_CNT) begin
            state_d = TX_IDLE;
            ser_d   = 1'b0;
            done_d  = 1'b1;
            cnt_d   = '0;
          end else begin
            ser_d = sh_q[0];
            sh_d  = {1'b0, sh_q[WORD_W-1:1]};
            cnt_d = cnt_q + 1'b1;
            vld_d = 1'b1;
          end
        end
      end
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      ser_q   <= 1'b0;
      vld_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      ser_q   <= ser_d;
      vld_q   <= vld_d;
      done_q  <= done_d;
    end
  end

  assign ser_o     = ser_q;
  assign bit_vld_o = vld_q;
  assign done_o    = done_q;
  assign busy_o    = (state_q == TX_SEND);
endmodule

// File: rtl/a429_word_tx.sv
module a429_word_tx
  import a429_tx_pkg::*;
#(
  parameter int unsigned WORD_W  = WORD_BITS,
  parameter int unsigned LABEL_W = LABEL_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              flip_i,
  input  logic              bit_tick_i,
  output logic              ser_o,
  output logic              bit_vld_o,
  output logic              done_o,
  output logic              busy_o
);
  localparam int unsigned BODY_W = WORD_W - 1;

  logic               rst_core_n;
  logic [LABEL_W-1:0] tx_label;
  logic [BODY_W-1:0]  body;
  logic               par;
  logic [WORD_W-1:0]  frame;

  a429_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  a429_label_order #(.LABEL_W(LABEL_W)) u_label (
    .label_i    (word_i[LABEL_W-1:0]),
    .flip_i     (flip_i),
    .tx_label_o (tx_label)
  );

  // Data bits keep their index order; host parity bit is dropped.
  assign body = {word_i[WORD_W-2:LABEL_W], tx_label};

  a429_parity_gen #(.BODY_W(BODY_W)) u_par (
    .body_i (body),
    .par_o  (par)
  );

  assign frame = {par, body};

  a429_bit_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .load_i    (load_i),
    .frame_i   (frame),
    .tick_i    (bit_tick_i),
    .ser_o     (ser_o),
    .bit_vld_o (bit_vld_o),
    .done_o    (done_o),
    .busy_o    (busy_o)
  );
endmodule

// File: rtl/a429_word_tx_chk.sv
module a429_word_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic load_i,
  input logic bit_tick_i,
  input logic ser_o,
  input logic bit_vld_o,
  input logic done_o,
  input logic busy_o
);
  // R1: an idle block keeps the line low
  a_r1_idle_line_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !ser_o);

  // R6: no strobe, no new bit
  a_r6_vld_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick_i |=> !bit_vld_o);

  // R6: line holds between strobes while busy
  a_r6_ser_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !bit_tick_i) |=> $stable(ser_o));

  // R7: done is a single-clock pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: done coincides with an idle, low line
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !ser_o));

  // R8: valid bits only while a word is in flight
  a_r8_vld_in_word: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld_o |-> busy_o);

  // R8: an idle load starts a word on the next clock
  a_r8_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !busy_o) |=> busy_o);
endmodule

bind a429_word_tx a429_word_tx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_i     (load_i),
  .bit_tick_i (bit_tick_i),
  .ser_o      (ser_o),
  .bit_vld_o  (bit_vld_o),
  .done_o     (done_o),
  .busy_o     (busy_o)
);

// File: tb/a429_word_tx_tb_top.sv
module a429_word_tx_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 6;
  // {flip, word}
  localparam logic [32:0] VECS [NVEC] = '{
    {1'b0, 32'h0000_00C1},
    {1'b1, 32'h0000_00C1},
    {1'b0, 32'hFFFF_FFFF},
    {1'b1, 32'h8000_0000},
    {1'b0, 32'h5A5A_A53E},
    {1'b1, 32'h7123_4507}
  };

  logic        clk;
  logic        rst_n;
  logic        load_i;
  logic [31:0] word_i;
  logic        flip_i;
  logic        bit_tick_i;
  logic        ser_o, bit_vld_o, done_o, busy_o;

  int n_chk;
  int n_fail;
  bit finished;

  a429_word_tx dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .word_i     (word_i),
    .flip_i     (flip_i),
    .bit_tick_i (bit_tick_i),
    .ser_o      (ser_o),
    .bit_vld_o  (bit_vld_o),
    .done_o     (done_o),
    .busy_o     (busy_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic exp_bit(input logic [31:0] w, input logic f, input int n);
    if (n <= 8)       return f ? w[n-1] : w[8-n];
    else if (n <= 31) return w[n-1];
    else              return ~(^w[30:0]);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic string req_of(input int n);
    if (n <= 8)  return "R2/R3";
    if (n <= 31) return "R4";
    return "R5";
  endfunction

  task automatic cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  // Load at a negedge; busy seen at next negedge.
  task automatic do_load(input logic [31:0] w, input logic f);
    word_i = w; flip_i = f; load_i = 1'b1;
    cyc(1);
    load_i = 1'b0;
    chk(busy_o === 1'b1, "R8", "busy after load", 32'(busy_o), 32'd1);
    // R9: disturb inputs after capture
    word_i = ~w; flip_i = ~f;
  endtask

  task automatic tick_once();
    bit_tick_i = 1'b1;
    cyc(1);
    bit_tick_i = 1'b0;
  endtask

  // Strobes bits first..last, checking each one; mid_load_at > 0 issues a load then.
  task automatic run_bits(input logic [31:0] w, input logic f, input int first,
                          input int last, input int mid_load_at);
    for (int n = first; n <= last; n++) begin
      if (n == mid_load_at) load_i = 1'b1;
      tick_once();
      load_i = 1'b0;
      chk(ser_o === exp_bit(w, f, n), req_of(n), $sformatf("bit %0d", n),
          32'(ser_o), 32'(exp_bit(w, f, n)));
      chk(bit_vld_o === 1'b1, "R6", "valid pulse", 32'(bit_vld_o), 32'd1);
      cyc(1);
      chk(bit_vld_o === 1'b0 && ser_o === exp_bit(w, f, n), "R6", "hold between strobes",
          {30'd0, bit_vld_o, ser_o}, {31'd0, exp_bit(w, f, n)});
      cyc(1);
    end
  endtask

  task automatic finish_word();
    tick_once();
    chk(done_o === 1'b1 && busy_o === 1'b0 && ser_o === 1'b0, "R7", "end of word",
        {29'd0, done_o, busy_o, ser_o}, 32'h4);
    cyc(1);
    chk(done_o === 1'b0, "R7", "done one clock", 32'(done_o), 32'd0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    n_chk = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0; load_i = 1'b0; word_i = '0; flip_i = 1'b0; bit_tick_i = 1'b0;
    cyc(3);
    chk({ser_o, bit_vld_o, done_o, busy_o} === 4'b0, "R1", "in reset",
        32'({ser_o, bit_vld_o, done_o, busy_o}), 32'd0);
    rst_n = 1'b1;
    cyc(4);
    chk({ser_o, bit_vld_o, done_o, busy_o} === 4'b0, "R1", "after reset",
        32'({ser_o, bit_vld_o, done_o, busy_o}), 32'd0);

    // Table walk: label orders R2/R3, data R4, parity R5, input capture R9
    for (int v = 0; v < NVEC; v++) begin
      do_load(VECS[v][31:0], VECS[v][32]);
      run_bits(VECS[v][31:0], VECS[v][32], 1, 32, 0);
      finish_word();
      cyc(2);
    end

    // R6: strobe while idle does nothing
    tick_once();
    chk({ser_o, bit_vld_o, busy_o} === 3'b0, "R6", "idle strobe",
        32'({ser_o, bit_vld_o, busy_o}), 32'd0);
    cyc(2);

    // R8: load while busy is ignored
    do_load(32'h1234_56A3, 1'b0);
    run_bits(32'h1234_56A3, 1'b0, 1, 32, 10);
    finish_word();
    cyc(3);
    chk(busy_o === 1'b0, "R8", "no second word", 32'(busy_o), 32'd0);

    // R1: reset in mid-word
    do_load(32'h0F0F_0FF0, 1'b1);
    run_bits(32'h0F0F_0FF0, 1'b1, 1, 5, 0);
    rst_n = 1'b0;
    cyc(1);
    chk({ser_o, bit_vld_o, done_o, busy_o} === 4'b0, "R1", "mid-word reset",
        32'({ser_o, bit_vld_o, done_o, busy_o}), 32'd0);
    rst_n = 1'b1;
    cyc(4);
    tick_once();
    chk({ser_o, bit_vld_o, busy_o} === 3'b0, "R1", "idle after reset",
        32'({ser_o, bit_vld_o, busy_o}), 32'd0);
    cyc(2);

    // R5: parity with odd-count body and forced top bit
    do_load(32'h8000_0001, 1'b0);
    run_bits(32'h8000_0001, 1'b0, 1, 32, 0);
    finish_word();
    cyc(2);
    summary();
  end
endmodule